// File: doc/BRIEF.md
# Scaled Add-Subtract and Compare Unit

This block is the integer arithmetic slice of a RISC-style execute stage. It is purely combinational: it takes operand A, a second operand that is either a register value or a small literal, and a 7-bit function code. In the same cycle it returns a 64-bit result and two flags. One flag reports signed overflow. The other reports an unknown function code.

The unit covers several operation groups:
- Quadword (64-bit) and longword (32-bit) addition and subtraction.
- Variants of those that multiply operand A by 4 or by 8 before the add or subtract.
- Five scalar compares, each returning 0 or 1.
- A lane compare that tests eight unsigned bytes at once and returns a bit mask.

Longword results are sign-extended from bit 31. Four function codes are marked as trapping. When one of them overflows, the wrapped result is still delivered, and the overflow flag is raised alongside it. Raising that flag is the unit's only trap duty; whatever handles the trap sits outside this block.

Top module: `scaled_addsub_unit`

## Requirements
- R1: Quadword add (0x20) and subtract (0x29) return A+B and A-B modulo 2^64.
- R2: The scaled codes shift A left by 2 (codes 0x02, 0x0b, 0x22, 0x2b) or by 3 (codes 0x12, 0x1b, 0x32, 0x3b) before the add or subtract. 0x02, 0x12, 0x0b and 0x1b are longword operations; the others are quadword.
- R3: Longword codes (0x00, 0x40, 0x02, 0x12, 0x09, 0x49, 0x0b, 0x1b) use only bits 31:0 of each operand, and the 32-bit result is sign-extended from bit 31 into bits 63:32.
- R4: The trapping add codes are 0x40 (longword) and 0x60 (quadword). They raise `ovf_trap` exactly when the sign bits of A and B are equal and the result sign bit differs from the sign bit of A. The sign bit is bit 31 for longword and bit 63 for quadword.
- R5: The trapping subtract codes are 0x49 (longword) and 0x69 (quadword). They raise `ovf_trap` exactly when the sign bits of A and B differ and the result sign bit differs from the sign bit of A.
- R6: Only codes 0x40, 0x60, 0x49 and 0x69 may raise `ovf_trap`; every other code holds it low. An overflowing operation still outputs its wrapped result.
- R7: The compare codes return 1 when the relation holds and 0 otherwise, with bits 63:1 always zero:
  - 0x2d: equal.
  - 0x4d: signed less-than.
  - 0x6d: signed less-or-equal.
  - 0x1d: unsigned less-than.
  - 0x3d: unsigned less-or-equal.
- R8: Code 0x0f sets result bit i (i = 0..7) when byte i of A (bits 8i+7:8i) is greater than or equal to byte i of B as unsigned values. Bits 63:8 of the result are zero.
- R9: When `use_lit` is 1, operand B is `lit_b` zero-extended to 64 bits, and `reg_b` has no effect on the outputs.
- R10: Any code not listed above drives `result` to zero, drives `illegal_func` high and drives `ovf_trap` low. Listed codes hold `illegal_func` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | Operand A |
| reg_b | input | 64 | Operand B taken from a register |
| lit_b | input | 8 | Literal operand B |
| use_lit | input | 1 | Selects the zero-extended literal as operand B |
| func | input | 7 | Function code |
| result | output | 64 | Operation result |
| ovf_trap | output | 1 | Signed overflow on a trapping code |
| illegal_func | output | 1 | Function code is not recognised |

## Verification
Sums are chosen to cross bit 31 and bit 63, so the tests separate a correct 32-bit sign extension from a plain 64-bit add. They also separate a wrap into the sign bit from an honest carry out of the word. Overflow cases pair each trap condition with a near miss: mixed signs for add, and equal operands for subtract. The same overflowing operands are also applied to the non-trapping code, which shows that the flag depends on the code. Compare tests use all-ones against zero, which gives opposite answers under signed and unsigned order. The byte-lane test mixes equal, greater, smaller and 0x80-versus-0x7f lanes, so an accidental signed lane compare is caught. Literal tests load a junk `reg_b` and a literal with bit 7 set, which exposes sign extension of the literal and any leakage from the register path.

// File: rtl/sau_pkg.sv
package sau_pkg;

  typedef enum logic [2:0] {
    OPK_ARITH,
    OPK_EQ,
    OPK_SLT,
    OPK_SLE,
    OPK_ULT,
    OPK_ULE,
    OPK_BYTEGE,
    OPK_NONE
  } op_kind_e;

  typedef struct packed {
    op_kind_e    kind;
    logic        sub;
    logic        longw;
    logic [1:0]  shamt;
    logic        trap;
    logic        legal;
  } op_ctl_t;

endpackage

// File: rtl/sau_decode.sv
module sau_decode
  import sau_pkg::*;
#(
  parameter int FUNC_W = 7
) (
  input  logic [FUNC_W-1:0] func,
  output op_ctl_t           ctl
);

  always_comb begin
    ctl.kind  = OPK_NONE;
    ctl.sub   = 1'b0;
    ctl.longw = 1'b0;
    ctl.shamt = 2'd0;
    ctl.trap  = 1'b0;
    ctl.legal = 1'b1;
    case (func)
      // additions
      7'h00: begin ctl.kind = OPK_ARITH; ctl.longw = 1'b1; end
      7'h40: begin ctl.kind = OPK_ARITH; ctl.longw = 1'b1; ctl.trap = 1'b1; end
      7'h02: begin ctl.kind = OPK_ARITH; ctl.longw = 1'b1; ctl.shamt = 2'd2; end
      7'h12: begin ctl.kind = OPK_ARITH; ctl.longw = 1'b1; ctl.shamt = 2'd3; end
      7'h20: begin ctl.kind = OPK_ARITH; end
      7'h60: begin ctl.kind = OPK_ARITH; ctl.trap = 1'b1; end
      7'h22: begin ctl.kind = OPK_ARITH; ctl.shamt = 2'd2; end
      7'h32: begin ctl.kind = OPK_ARITH; ctl.shamt = 2'd3; end
      // subtractions
      7'h09: begin ctl.kind = OPK_ARITH; ctl.sub = 1'b1; ctl.longw = 1'b1; end
      7'h49: begin ctl.kind = OPK_ARITH; ctl.sub = 1'b1; ctl.longw = 1'b1; ctl.trap = 1'b1; end
      7'h0b: begin ctl.kind = OPK_ARITH; ctl.sub = 1'b1; ctl.longw = 1'b1; ctl.shamt = 2'd2; end
      7'h1b: begin ctl.kind = OPK_ARITH; ctl.sub = 1'b1; ctl.longw = 1'b1; ctl.shamt = 2'd3; end
      7'h29: begin ctl.kind = OPK_ARITH; ctl.sub = 1'b1; end
      7'h69: begin ctl.kind = OPK_ARITH; ctl.sub = 1'b1; ctl.trap = 1'b1; end
      7'h2b: begin ctl.kind = OPK_ARITH; ctl.sub = 1'b1; ctl.shamt = 2'd2; end
      7'h3b: begin ctl.kind = OPK_ARITH; ctl.sub = 1'b1; ctl.shamt = 2'd3; end
      // compares
      7'h2d: ctl.kind = OPK_EQ;
      7'h4d: ctl.kind = OPK_SLT;
      7'h6d: ctl.kind = OPK_SLE;
      7'h1d: ctl.kind = OPK_ULT;
      7'h3d: ctl.kind = OPK_ULE;
      7'h0f: ctl.kind = OPK_BYTEGE;
      default: ctl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/sau_addsub.sv
module sau_addsub #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              longw,
  input  logic [1:0]        shamt,
  input  logic              trap,
  output logic [DATA_W-1:0] res,
  output logic              ovf
);

  logic [DATA_W-1:0] a_sc;
  logic [DATA_W-1:0] sum;
  logic              sgn_a, sgn_b, sgn_r;

  always_comb begin
    a_sc  = a << shamt;
    sum   = sub ? (a_sc - b) : (a_sc + b);
    if (longw) begin
      res   = {{(DATA_W-HALF_W){sum[HALF_W-1]}}, sum[HALF_W-1:0]};
      sgn_a = a_sc[HALF_W-1];
      sgn_b = b[HALF_W-1];
      sgn_r = sum[HALF_W-1];
    end else begin
      res   = sum;
      sgn_a = a_sc[DATA_W-1];
      sgn_b = b[DATA_W-1];
      sgn_r = sum[DATA_W-1];
    end
    ovf = trap & (sub ? (sgn_a != sgn_b) : (sgn_a == sgn_b)) & (sgn_r != sgn_a);
  end

endmodule

// File: rtl/sau_cmp.sv
module sau_cmp
  import sau_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  op_kind_e          kind,
  output logic [DATA_W-1:0] res
);

  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] lane_ge;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_ge[i] = a[i*LANE_W +: LANE_W] >= b[i*LANE_W +: LANE_W];
  end

  logic is_eq, is_slt, is_ult;

  always_comb begin
    is_eq  = (a == b);
    is_slt = ($signed(a) < $signed(b));
    is_ult = (a < b);
    res    = '0;
    case (kind)
      OPK_EQ:     res[0] = is_eq;
      OPK_SLT:    res[0] = is_slt;
      OPK_SLE:    res[0] = is_slt | is_eq;
      OPK_ULT:    res[0] = is_ult;
      OPK_ULE:    res[0] = is_ult | is_eq;
      OPK_BYTEGE: res[LANES-1:0] = lane_ge;
      default:    res = '0;
    endcase
  end

endmodule

// File: rtl/scaled_addsub_unit.sv
module scaled_addsub_unit
  import sau_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8,
  parameter int FUNC_W = 7
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [LIT_W-1:0]  lit_b,
  input  logic              use_lit,
  input  logic [FUNC_W-1:0] func,
  output logic [DATA_W-1:0] result,
  output logic              ovf_trap,
  output logic              illegal_func
);

  localparam int HALF_W = DATA_W / 2;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  op_ctl_t           ctl;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] arith_res, cmp_res;
  logic              arith_ovf;

  assign b_eff = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit_b} : reg_b;

  sau_decode #(.FUNC_W(FUNC_W)) u_dec (
    .func (func),
    .ctl  (ctl)
  );

  sau_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_add (
    .a     (op_a),
    .b     (b_eff),
    .sub   (ctl.sub),
    .longw (ctl.longw),
    .shamt (ctl.shamt),
    .trap  (ctl.trap),
    .res   (arith_res),
    .ovf   (arith_ovf)
  );

  sau_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .a    (op_a),
    .b    (b_eff),
    .kind (ctl.kind),
    .res  (cmp_res)
  );

  always_comb begin
    illegal_func = ~ctl.legal;
    ovf_trap     = 1'b0;
    result       = '0;
    if (ctl.kind == OPK_ARITH) begin
      result   = arith_res;
      ovf_trap = arith_ovf;
    end else if (ctl.kind != OPK_NONE) begin
      result   = cmp_res;
    end
  end

  // Cross-unit checks between decoder, datapath and output mux
  always_comb begin
    if (illegal_func) begin
      assert_illegal_zero_R10: assert (result == '0 && !ovf_trap)
        else $error("illegal code produced data or trap");
    end
    if (ovf_trap) begin
      assert_no_overflow_R6: assert (ctl.trap && ctl.kind == OPK_ARITH)
        else $error("overflow flag on a non-trapping code");
    end
    if (ctl.kind == OPK_BYTEGE) begin
      assert_lane_upper_R8: assert (result[DATA_W-1:LANES] == '0)
        else $error("byte compare upper bits not zero");
    end
    if (ctl.kind inside {OPK_EQ, OPK_SLT, OPK_SLE, OPK_ULT, OPK_ULE}) begin
      assert_bool_cmp_R7: assert (result[DATA_W-1:1] == '0)
        else $error("scalar compare not 0 or 1");
    end
    if (ctl.kind == OPK_ARITH && ctl.longw) begin
      assert_long_sext_R3: assert (result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}})
        else $error("longword result not sign extended");
    end
  end

endmodule

// File: tb/scaled_addsub_unit_tb.sv
module scaled_addsub_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [63:0] op_a, reg_b, result;
  logic [7:0]  lit_b;
  logic        use_lit, ovf_trap, illegal_func;
  logic [6:0]  func;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  scaled_addsub_unit u_dut (
    .op_a (op_a), .reg_b (reg_b), .lit_b (lit_b), .use_lit (use_lit),
    .func (func), .result (result), .ovf_trap (ovf_trap),
    .illegal_func (illegal_func)
  );

  task automatic apply(input logic [6:0] f, input logic [63:0] a,
                       input logic [63:0] rb, input logic ul, input logic [7:0] l);
    @(posedge clk);
    #1;
    func = f; op_a = a; reg_b = rb; use_lit = ul; lit_b = l;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] er,
                       input logic eo, input logic ei);
    total++;
    if (result !== er || ovf_trap !== eo || illegal_func !== ei) begin
      bad++;
      $display("FAIL %s: result=%h ovf=%b ill=%b expected result=%h ovf=%b ill=%b",
               req, result, ovf_trap, illegal_func, er, eo, ei);
    end
  endtask

  task automatic t_reset;
    apply(7'h00, 64'd0, 64'd0, 1'b0, 8'd0);
    check("R10 idle after reset", 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_quad_R1;
    apply(7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 1'b0, 8'd0);
    check("R1 addq wrap", 64'd1, 1'b0, 1'b0);
    apply(7'h29, 64'd5, 64'd7, 1'b0, 8'd0);
    check("R1 subq borrow", 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0);
  endtask

  task automatic t_scaled_R2;
    apply(7'h22, 64'd3, 64'd10, 1'b0, 8'd0);
    check("R2 s4addq", 64'd22, 1'b0, 1'b0);
    apply(7'h3b, 64'd2, 64'd1, 1'b0, 8'd0);
    check("R2 s8subq", 64'd15, 1'b0, 1'b0);
    apply(7'h12, 64'h0000_0000_1000_0000, 64'd0, 1'b0, 8'd0);
    check("R2 s8addl", 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0);
    apply(7'h0b, 64'd1, 64'd5, 1'b0, 8'd0);
    check("R2 s4subl", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_long_R3;
    apply(7'h00, 64'hAAAA_AAAA_7FFF_FFFF, 64'd1, 1'b0, 8'd0);
    check("R3 addl sext", 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0);
    apply(7'h09, 64'h1234_0000_0000_0005, 64'hFFFF_0000_0000_0003, 1'b0, 8'd0);
    check("R3 subl low half", 64'd2, 1'b0, 1'b0);
  endtask

  task automatic t_add_ovf_R4;
    apply(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 8'd0);
    check("R4 addqv pos ovf", 64'h8000_0000_0000_0000, 1'b1, 1'b0);
    apply(7'h60, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 8'd0);
    check("R4 addqv neg ovf", 64'd0, 1'b1, 1'b0);
    apply(7'h60, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 8'd0);
    check("R4 addqv mixed no ovf", 64'd0, 1'b0, 1'b0);
    apply(7'h40, 64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0, 8'd0);
    check("R4 addlv ovf", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_sub_ovf_R5;
    apply(7'h69, 64'h8000_0000_0000_0000, 64'd1, 1'b0, 8'd0);
    check("R5 subqv ovf", 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    apply(7'h69, 64'd5, 64'd5, 1'b0, 8'd0);
    check("R5 subqv equal no ovf", 64'd0, 1'b0, 1'b0);
    apply(7'h49, 64'h0000_0000_8000_0000, 64'd1, 1'b0, 8'd0);
    check("R5 sublv ovf", 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_notrap_R6;
    apply(7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 8'd0);
    check("R6 addq no flag", 64'h8000_0000_0000_0000, 1'b0, 1'b0);
    apply(7'h09, 64'h0000_0000_8000_0000, 64'd1, 1'b0, 8'd0);
    check("R6 subl no flag", 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_cmp_R7;
    apply(7'h2d, 64'd5, 64'd5, 1'b0, 8'd0);
    check("R7 eq", 64'd1, 1'b0, 1'b0);
    apply(7'h4d, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 8'd0);
    check("R7 signed lt", 64'd1, 1'b0, 1'b0);
    apply(7'h1d, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 8'd0);
    check("R7 unsigned lt", 64'd0, 1'b0, 1'b0);
    apply(7'h6d, 64'd3, 64'd3, 1'b0, 8'd0);
    check("R7 signed le", 64'd1, 1'b0, 1'b0);
    apply(7'h3d, 64'd4, 64'd3, 1'b0, 8'd0);
    check("R7 unsigned le", 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_bytes_R8;
    apply(7'h0f, 64'h00FF_1080_0000_7F01, 64'h0100_1080_FF00_8001, 1'b0, 8'd0);
    check("R8 lane mask", 64'h0000_0000_0000_0075, 1'b0, 1'b0);
  endtask

  task automatic t_literal_R9;
    apply(7'h20, 64'd1, 64'hDEAD_BEEF_0000_1234, 1'b1, 8'hFF);
    check("R9 literal add", 64'h0000_0000_0000_0100, 1'b0, 1'b0);
    apply(7'h4d, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 8'h90);
    check("R9 literal not sign extended", 64'd1, 1'b0, 1'b0);
  endtask

  task automatic t_illegal_R10;
    apply(7'h7F, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 8'd0);
    check("R10 code 7f", 64'd0, 1'b0, 1'b1);
    apply(7'h01, 64'd9, 64'd9, 1'b0, 8'd0);
    check("R10 code 01", 64'd0, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    func = 7'h00; op_a = '0; reg_b = '0; use_lit = 1'b0; lit_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_quad_R1();
    t_scaled_R2();
    t_long_R3();
    t_add_ovf_R4();
    t_sub_ovf_R5();
    t_notrap_R6();
    t_cmp_R7();
    t_bytes_R8();
    t_literal_R9();
    t_illegal_R10();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: rst_n=%b run did not complete, expected completion", rst_n);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule